// File: doc/BRIEF.md
# Serial-to-Bus Bridge

This block is an SPI slave that lets a host processor reach a 16-bit Wishbone bus. The host frames every transaction with an active-low slave select. The first 16-bit word after select falls is a command word. It carries a word address, a flag that asks for an auto-incrementing burst, and a flag that picks read or write. Any number of 16-bit data words follow the command word, and each one turns into one Wishbone cycle.

The serial side runs SPI mode 0 with the most significant bit first. The block samples the serial clock, MOSI and slave select in the system clock domain, through a synchroniser chain of selectable depth. For reads, the bridge fetches data ahead of time: it starts the bus read as soon as the command word is complete. After that, it starts the next read each time a word is placed in the output shifter. The returned word is therefore ready by the time the host clocks it out.

Top module: `spi_wb_bridge`

## Requirements
- R1: While and right after reset, `wb_cyc_o` and `wb_stb_o` are low and `spi_miso` is low.
- R2: The first word after `spi_ss_n` falls is the command word. Bits 15..2 are the word address, bit 1 = 1 requests a burst, and bit 0 = 1 selects a read while bit 0 = 0 selects a write.
- R3: In a write transaction, each complete 16-bit data word (MSB first, sampled on rising SCLK) produces exactly one Wishbone write of that word to the current address, with every bit of `wb_sel_o` set.
- R4: Without the burst flag, every data word of the transaction uses the commanded address.
- R5: With the burst flag, the address used for successive data words rises by one per word, starting at the commanded address.
- R6: In a read transaction, the word read from the commanded address is shifted out on `spi_miso` during the word slot right after the command word, MSB first, with each bit changing after a falling SCLK edge.
- R7: In a burst read, the word slots after the command word return the data at the commanded address, then address+1, address+2, and so on.
- R8: Once `wb_stb_o` is raised, it stays high together with `wb_cyc_o`, and the address, write enable and write data stay unchanged, until a cycle in which `wb_ack_i` is high. The bridge works with any acknowledge latency.
- R9: If `spi_ss_n` rises before a data word is complete, the partial word is dropped and no write cycle is issued for it.
- R10: A rise of `spi_ss_n` ends any burst. The next transaction starts again with a command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_ss_n | input | 1 | Active-low slave select, frames a transaction |
| spi_miso | output | 1 | Serial data to the host |
| wb_cyc_o | output | 1 | Bus cycle valid |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 14 | Bus word address |
| wb_dat_o | output | 16 | Bus write data |
| wb_sel_o | output | 2 | Byte selects, all set on every cycle |
| wb_dat_i | input | 16 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The checks on the bus handshake assume that the slave raises `wb_ack_i` only while `wb_stb_o` is high, and holds it for a single cycle. The bench's slave model acknowledges after 0 to 2 wait cycles and then drops the acknowledge. The checks also assume that the host keeps each SCLK half period longer than the synchroniser delay plus one bus round trip, so that prefetched read data lands before the next falling edge. The bench drives SCLK with eight system clocks per half period and holds slave select steady around every serial edge.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned SWB_WORD_W = 16;
  localparam int unsigned SWB_ADR_W  = SWB_WORD_W - 2;
  localparam int unsigned SWB_SEL_W  = SWB_WORD_W / 8;

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  typedef struct packed {
    logic                  we;
    logic [SWB_ADR_W-1:0]  adr;
    logic [SWB_WORD_W-1:0] dat;
  } bus_req_t;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swb_shifter.sv
// Serial word engine: collects MOSI bits on rising SCLK, and shifts MISO on
// falling SCLK. It loads a fresh outgoing word on the falling edge that
// follows a completed word.
module swb_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              ss_n,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              tx_load,
  output logic              miso
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  bitcnt;
  logic [WORD_W-1:0] rx_sr;
  logic [WORD_W-1:0] tx_sr;

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      bitcnt   <= '0;
      rx_sr    <= '0;
      rx_word  <= '0;
      tx_sr    <= '0;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (ss_n) begin
        bitcnt <= '0;
      end else if (rise) begin
        rx_sr  <= {rx_sr[WORD_W-2:0], mosi};
        bitcnt <= (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
        if (bitcnt == LAST_BIT) begin
          rx_word  <= {rx_sr[WORD_W-2:0], mosi};
          rx_valid <= 1'b1;
        end
      end else if (fall) begin
        if (bitcnt == '0) begin
          tx_sr   <= tx_word;
          tx_load <= 1'b1;
        end else begin
          tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sr[WORD_W-1];
endmodule

// File: rtl/swb_ctrl.sv
// Transaction sequencer: decodes the command word, tracks the word address,
// and asks for one bus cycle per data word (writes) or per load (reads).
module swb_ctrl
  import swb_pkg::*;
#(
  parameter int unsigned WORD_W = SWB_WORD_W,
  parameter int unsigned ADR_W  = SWB_ADR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              tx_load,
  output logic              req_v,
  output bus_req_t          req
);
  localparam int unsigned FLAG_BURST = 1;
  localparam int unsigned FLAG_READ  = 0;

  phase_t           phase;
  logic             burst, rd;
  logic [ADR_W-1:0] ptr;
  logic [ADR_W-1:0] ptr_next;

  assign ptr_next = burst ? ptr + 1'b1 : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD;
      burst <= 1'b0;
      rd    <= 1'b0;
      ptr   <= '0;
      req_v <= 1'b0;
      req   <= '0;
    end else begin
      req_v <= 1'b0;
      if (ss_n) begin
        phase <= PH_CMD;
      end else if (rx_valid) begin
        if (phase == PH_CMD) begin
          ptr   <= rx_word[WORD_W-1:2];
          burst <= rx_word[FLAG_BURST];
          rd    <= rx_word[FLAG_READ];
          phase <= PH_DATA;
          if (rx_word[FLAG_READ]) begin
            req_v   <= 1'b1;
            req.we  <= 1'b0;
            req.adr <= rx_word[WORD_W-1:2];
            req.dat <= '0;
          end
        end else if (!rd) begin
          req_v   <= 1'b1;
          req.we  <= 1'b1;
          req.adr <= ptr;
          req.dat <= rx_word;
          ptr     <= ptr_next;
        end
      end else if (tx_load && phase == PH_DATA && rd) begin
        // prefetch for the following word slot
        ptr     <= ptr_next;
        req_v   <= 1'b1;
        req.we  <= 1'b0;
        req.adr <= ptr_next;
        req.dat <= '0;
      end
    end
  end
endmodule

// File: rtl/swb_wb_master.sv
// Single-outstanding bus master with a one-entry holding slot for a request
// that arrives while a cycle is still waiting for acknowledge.
module swb_wb_master
  import swb_pkg::*;
#(
  parameter int unsigned WORD_W = SWB_WORD_W,
  parameter int unsigned ADR_W  = SWB_ADR_W,
  parameter int unsigned SEL_W  = SWB_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_v,
  input  bus_req_t          req,
  output logic              cyc,
  output logic              stb,
  output logic              we,
  output logic [ADR_W-1:0]  adr,
  output logic [WORD_W-1:0] dat_o,
  output logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] dat_i,
  input  logic              ack,
  output logic [WORD_W-1:0] rd_data
);
  logic     hold_v;
  bus_req_t hold;
  logic     free;
  bus_req_t launch;

  assign free   = !stb || ack;
  assign launch = hold_v ? hold : req;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc     <= 1'b0;
      stb     <= 1'b0;
      we      <= 1'b0;
      adr     <= '0;
      dat_o   <= '0;
      sel     <= '0;
      rd_data <= '0;
      hold_v  <= 1'b0;
      hold    <= '0;
    end else begin
      if (stb && ack) begin
        cyc <= 1'b0;
        stb <= 1'b0;
        if (!we) rd_data <= dat_i;
      end
      if (free && (hold_v || req_v)) begin
        cyc   <= 1'b1;
        stb   <= 1'b1;
        we    <= launch.we;
        adr   <= launch.adr;
        dat_o <= launch.dat;
        sel   <= '1;
        if (hold_v && req_v) hold <= req;
        else hold_v <= 1'b0;
      end else if (req_v) begin
        hold   <= req;
        hold_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_wb_bridge.sv
module spi_wb_bridge
  import swb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sclk,
  input  logic                  spi_mosi,
  input  logic                  spi_ss_n,
  output logic                  spi_miso,
  output logic                  wb_cyc_o,
  output logic                  wb_stb_o,
  output logic                  wb_we_o,
  output logic [SWB_ADR_W-1:0]  wb_adr_o,
  output logic [SWB_WORD_W-1:0] wb_dat_o,
  output logic [SWB_SEL_W-1:0]  wb_sel_o,
  input  logic [SWB_WORD_W-1:0] wb_dat_i,
  input  logic                  wb_ack_i
);
  logic [2:0]            pins_s;
  logic                  sclk_s, mosi_s, ss_n_s;
  logic [SWB_WORD_W-1:0] rx_word, rd_data;
  logic                  rx_valid, tx_load, req_v;
  bus_req_t              req;

  swb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_ss_n, spi_mosi, spi_sclk}),
    .q(pins_s)
  );
  assign {ss_n_s, mosi_s, sclk_s} = pins_s;

  swb_shifter #(.WORD_W(SWB_WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk(sclk_s), .mosi(mosi_s), .ss_n(ss_n_s),
    .tx_word(rd_data),
    .rx_word(rx_word), .rx_valid(rx_valid),
    .tx_load(tx_load), .miso(spi_miso)
  );

  swb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ss_n(ss_n_s),
    .rx_word(rx_word), .rx_valid(rx_valid), .tx_load(tx_load),
    .req_v(req_v), .req(req)
  );

  swb_wb_master u_wb (
    .clk(clk), .rst(rst), .req_v(req_v), .req(req),
    .cyc(wb_cyc_o), .stb(wb_stb_o), .we(wb_we_o), .adr(wb_adr_o),
    .dat_o(wb_dat_o), .sel(wb_sel_o), .dat_i(wb_dat_i), .ack(wb_ack_i),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/swb_bridge_checks.sv
module swb_bridge_checks
  import swb_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  wb_cyc_o,
  input logic                  wb_stb_o,
  input logic                  wb_we_o,
  input logic [SWB_ADR_W-1:0]  wb_adr_o,
  input logic [SWB_WORD_W-1:0] wb_dat_o,
  input logic [SWB_SEL_W-1:0]  wb_sel_o,
  input logic                  wb_ack_i
);
  // R1: a reset cycle leaves the bus idle
  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!wb_stb_o && !wb_cyc_o));

  // R8: cycle and strobe move together
  p_cyc_with_stb_r8: assert property (@(posedge clk) disable iff (rst)
    wb_cyc_o == wb_stb_o);

  // R8: an unacknowledged strobe keeps its request unchanged
  p_hold_request_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_o && !wb_ack_i) |=>
      (wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));

  // R3: all byte lanes enabled on every cycle
  p_full_select_r3: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> (wb_sel_o == {SWB_SEL_W{1'b1}}));
endmodule

bind spi_wb_bridge swb_bridge_checks u_checks (
  .clk(clk), .rst(rst),
  .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
  .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o),
  .wb_ack_i(wb_ack_i)
);

// File: tb/spi_wb_bridge_bench.sv
module spi_wb_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0, spi_mosi = 1'b0, spi_ss_n = 1'b1;
  logic        spi_miso;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [13:0] wb_adr_o;
  logic [15:0] wb_dat_o;
  logic [1:0]  wb_sel_o;
  logic [15:0] wb_dat_i = '0;
  logic        wb_ack_i = 1'b0;

  int n_checks = 0, n_fail = 0;
  int wr_count = 0;
  int ack_delay = 0;
  int wcnt = 0;
  logic [15:0] mem [64];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wb_bridge u_spi_wb_bridge (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
    .spi_miso(spi_miso),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o),
    .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
  );

  // bus slave model: memory with programmable acknowledge latency
  always @(posedge clk) begin
    if (wb_ack_i) begin
      wb_ack_i <= 1'b0;
    end else if (wb_stb_o) begin
      if (wcnt >= ack_delay) begin
        wcnt     <= 0;
        wb_ack_i <= 1'b1;
        wb_dat_i <= mem[wb_adr_o[5:0]];
        if (wb_we_o) begin
          mem[wb_adr_o[5:0]] <= wb_dat_o;
          wr_count <= wr_count + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ss_begin();
    spi_ss_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic ss_end();
    wait_clk(HALF);
    spi_ss_n = 1'b1;
    wait_clk(4*HALF);
  endtask

  task automatic spi_word(input logic [15:0] tx, output logic [15:0] rx);
    for (int i = 15; i >= 0; i--) begin
      spi_mosi = tx[i];
      wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  function automatic logic [15:0] cmd(input int a, input bit burst, input bit rd);
    return {a[13:0], burst, rd};
  endfunction

  task automatic t_reset();
    wait_clk(1);
    check("R1 cyc", {15'd0, wb_cyc_o}, 16'd0);
    check("R1 stb", {15'd0, wb_stb_o}, 16'd0);
    check("R1 miso", {15'd0, spi_miso}, 16'd0);
  endtask

  task automatic t_single_write();
    logic [15:0] rx;
    int w0 = wr_count;
    ss_begin();
    spi_word(cmd(5, 0, 0), rx);
    spi_word(16'hA5C3, rx);
    ss_end();
    check("R3 single write data", mem[5], 16'hA5C3);
    check("R3 one write cycle", 16'(wr_count - w0), 16'd1);
    check("R2 neighbour untouched", mem[4], 16'h0104);
  endtask

  task automatic t_nonburst_multi();
    logic [15:0] rx;
    int w0 = wr_count;
    ss_begin();
    spi_word(cmd(7, 0, 0), rx);
    spi_word(16'h1111, rx);
    spi_word(16'h2222, rx);
    spi_word(16'h3333, rx);
    ss_end();
    check("R4 same address last word", mem[7], 16'h3333);
    check("R4 next address untouched", mem[8], 16'h0108);
    check("R4 three cycles", 16'(wr_count - w0), 16'd3);
  endtask

  task automatic t_burst_write();
    logic [15:0] rx;
    ss_begin();
    spi_word(cmd(10, 1, 0), rx);
    for (int i = 0; i < 4; i++) spi_word(16'hB000 + 16'(i), rx);
    ss_end();
    for (int i = 0; i < 4; i++) check("R5 burst write", mem[10+i], 16'hB000 + 16'(i));
    check("R5 burst stops", mem[14], 16'h010E);
  endtask

  task automatic t_single_read();
    logic [15:0] rx;
    mem[30] = 16'hBEEF;
    mem[31] = 16'h4321;
    ss_begin();
    spi_word(cmd(30, 0, 1), rx);
    spi_word(16'h0000, rx);
    check("R6 read word", rx, 16'hBEEF);
    spi_word(16'h0000, rx);
    check("R4 read same address", rx, 16'hBEEF);
    ss_end();
    check("R2 read leaves memory", mem[30], 16'hBEEF);
  endtask

  task automatic t_burst_read();
    logic [15:0] rx;
    for (int i = 0; i < 4; i++) mem[40+i] = 16'hC0DE ^ 16'(i * 16'h1111);
    ack_delay = 2;
    ss_begin();
    spi_word(cmd(40, 1, 1), rx);
    for (int i = 0; i < 4; i++) begin
      spi_word(16'h0000, rx);
      check("R7 burst read", rx, 16'hC0DE ^ 16'(i * 16'h1111));
    end
    ss_end();
    ack_delay = 0;
  endtask

  task automatic t_slow_ack_write();
    logic [15:0] rx;
    ack_delay = 2;
    ss_begin();
    spi_word(cmd(20, 1, 0), rx);
    spi_word(16'h5A5A, rx);
    spi_word(16'hA5A5, rx);
    ss_end();
    ack_delay = 0;
    check("R8 slow ack word0", mem[20], 16'h5A5A);
    check("R8 slow ack word1", mem[21], 16'hA5A5);
  endtask

  task automatic t_abort();
    logic [15:0] rx;
    logic [15:0] part = 16'hFFFF;
    int w0 = wr_count;
    ss_begin();
    spi_word(cmd(50, 0, 0), rx);
    for (int i = 15; i >= 9; i--) begin
      spi_mosi = part[i];
      wait_clk(HALF);
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    ss_end();
    check("R9 partial word dropped", mem[50], 16'h0132);
    check("R9 no cycle", 16'(wr_count - w0), 16'd0);
  endtask

  task automatic t_burst_end();
    logic [15:0] rx;
    ss_begin();
    spi_word(cmd(60, 1, 0), rx);
    spi_word(16'h6060, rx);
    spi_word(16'h6161, rx);
    ss_end();
    ss_begin();
    spi_word(cmd(3, 0, 0), rx);
    spi_word(16'h7777, rx);
    ss_end();
    check("R10 burst data", mem[61], 16'h6161);
    check("R10 burst ended", mem[62], 16'h013E);
    check("R10 fresh command", mem[3], 16'h7777);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0100 + 16'(i);
    wait_clk(5);
    t_reset();
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_single_write();
    t_nonburst_multi();
    t_burst_write();
    t_single_read();
    t_burst_read();
    t_slow_ack_write();
    t_abort();
    t_burst_end();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule